// File: doc/BRIEF.md
# Masked-Write GPIO Bank with Shared Interrupt

A sixteen-pin general purpose I/O bank reached through a simple memory-mapped register port. Software chooses each pin's direction, drives output levels, reads back synchronized pin levels, and picks which of the upper eight pins may raise a common interrupt. Output latches are updated by a single write that carries both new values and a per-bit mask, so any subset of pins can change without a read-modify-write race.

The bank has its own control register with a clock-enable bit and a block-reset bit. It leaves system reset held in block reset with its clock stopped, and does nothing until software writes 3 (reset, clock running) and then 1 (running). Writing 2 parks it in reset with the clock stopped; writing 0 freezes all state while ignoring every register write but the control register.

Top module: `gpio16_mask_bank`

## Requirements
- R1: After system reset the control register reads 2 (bit 1 block reset, bit 0 clock enable), direction, output and interrupt-enable registers read 0, pin_oe and pin_out are 0 and both interrupt outputs are low.
- R2: While running (control = 1) a write to offset 0x00 sets the direction register from data bits 15:0; bit n = 1 drives pin_oe[n] high (output), and the register reads back at 0x00 in bits 15:0.
- R3: While running, a write to offset 0x08 loads output latch n from data bit n only where data bit n+16 is 1; other latches keep their value. Latches appear on pin_out and read back at 0x08 in bits 15:0.
- R4: Offset 0x0C reads the pin levels in bits 15:0 through a two-stage synchronizer: a pin change is visible two clock cycles later and not after one.
- R5: Offset 0x10 holds enables for pins 8..15 in bits 0..7; irq_shared is high when any of pins 8..15 (synchronized) is high with its enable bit set, and low otherwise.
- R6: irq_direct[7:0] follows the synchronized levels of pins 0..7 with no enable gating.
- R7: Offset 0x14 reads the two control bits; while bit 1 is set, direction, output latches, interrupt enables and synchronized levels are held at 0 and writes to other registers are ignored.
- R8: With control = 0 (clock stopped, not in reset) all state holds: writes to offsets other than 0x14 have no effect and the pin-state reading stays frozen; writing 1 resumes with the held values.
- R9: Reads of unmapped offsets (for example 0x04) return 0, and writes there change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low system reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| pin_in | input | 16 | Pin levels from the pads |
| pin_out | output | 16 | Output latch values |
| pin_oe | output | 16 | Output enables (1 = drive) |
| irq_shared | output | 1 | Shared request of pins 8..15 |
| irq_direct | output | 8 | Ungated requests of pins 0..7 |

## Verification
On every cycle the assertions check the masked latch update, the direction load, the clearing effect of the block-reset bit, the frozen state with the clock stopped, the two-cycle lag of the direct requests and that the shared request never rises with all enables clear. Only the bench scenarios show the enable sequence from the reset value, a register surviving a stop and restart, the exact cycle a pin change reaches the pin-state register, and the read map including unmapped offsets.

// File: rtl/gpio16_mask_bank.sv
module gpio16_mask_bank #(
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [15:0]       pin_in,
  output logic [15:0]       pin_out,
  output logic [15:0]       pin_oe,
  output logic              irq_shared,
  output logic [7:0]        irq_direct
);
  localparam logic [ADDR_W-1:0] A_DIR  = ADDR_W'('h00);
  localparam logic [ADDR_W-1:0] A_OUT  = ADDR_W'('h08);
  localparam logic [ADDR_W-1:0] A_PIN  = ADDR_W'('h0C);
  localparam logic [ADDR_W-1:0] A_IEN  = ADDR_W'('h10);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'('h14);

  logic [1:0]  ctrl_q;
  logic [15:0] dir_q, out_q;
  logic [7:0]  ien_q;
  logic [15:0] sync_q [SYNC_STAGES];
  logic [15:0] pin_lvl;
  logic        running, wr_ok;

  assign running = (ctrl_q == 2'b01);
  assign wr_ok   = bus_wr & running;
  assign pin_lvl = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) ctrl_q <= 2'b10;
    else if (bus_wr && bus_addr == A_CTRL) ctrl_q <= bus_wdata[1:0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      dir_q <= '0;
      out_q <= '0;
      ien_q <= '0;
    end else if (ctrl_q[1]) begin
      dir_q <= '0;
      out_q <= '0;
      ien_q <= '0;
    end else if (wr_ok) begin
      if (bus_addr == A_DIR) dir_q <= bus_wdata[15:0];
      if (bus_addr == A_OUT) out_q <= (out_q & ~bus_wdata[31:16]) | (bus_wdata[15:0] & bus_wdata[31:16]);
      if (bus_addr == A_IEN) ien_q <= bus_wdata[7:0];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < SYNC_STAGES; i++) sync_q[i] <= '0;
    end else if (ctrl_q[1]) begin
      for (int i = 0; i < SYNC_STAGES; i++) sync_q[i] <= '0;
    end else if (ctrl_q[0]) begin
      sync_q[0] <= pin_in;
      for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
    end

  always_comb
    case (bus_addr)
      A_DIR:   bus_rdata = {16'h0, dir_q};
      A_OUT:   bus_rdata = {16'h0, out_q};
      A_PIN:   bus_rdata = {16'h0, pin_lvl};
      A_IEN:   bus_rdata = {24'h0, ien_q};
      A_CTRL:  bus_rdata = {30'h0, ctrl_q};
      default: bus_rdata = '0;
    endcase

  assign pin_out    = out_q;
  assign pin_oe     = dir_q;
  assign irq_direct = pin_lvl[7:0];
  assign irq_shared = |(pin_lvl[15:8] & ien_q);
endmodule

// File: rtl/gpio16_mask_bank_chk.sv
module gpio16_mask_bank_chk #(
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic [1:0]        ctrl_q,
  input logic [7:0]        ien_q,
  input logic [15:0]       pin_in,
  input logic [15:0]       pin_out,
  input logic [15:0]       pin_oe,
  input logic              irq_shared,
  input logic [7:0]        irq_direct
);
  logic run;
  assign run = (ctrl_q == 2'b01);

  assert_dir_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    run && bus_wr && bus_addr == ADDR_W'('h00) |=> pin_oe == $past(bus_wdata[15:0]));

  assert_masked_out_R3: assert property (@(posedge clk) disable iff (!rst_n)
    run && bus_wr && bus_addr == ADDR_W'('h08) |=>
      pin_out == (($past(pin_out) & ~$past(bus_wdata[31:16])) | ($past(bus_wdata[15:0]) & $past(bus_wdata[31:16]))));

  assert_shared_needs_enable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_shared |-> ien_q != 8'h00);

  generate if (SYNC_STAGES == 2) begin : g_lag
    assert_direct_lag_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $past(run) && $past(run, 2) |-> irq_direct == $past(pin_in[7:0], 2));
  end endgenerate

  assert_block_reset_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q[1] |=> pin_oe == 16'h0 && pin_out == 16'h0 && ien_q == 8'h0 && !irq_shared);

  assert_stopped_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q == 2'b00 |=> $stable(pin_oe) && $stable(pin_out) && $stable(ien_q) && $stable(irq_direct));
endmodule

bind gpio16_mask_bank gpio16_mask_bank_chk #(.ADDR_W(ADDR_W), .SYNC_STAGES(SYNC_STAGES)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .ctrl_q(ctrl_q), .ien_q(ien_q), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
  .irq_shared(irq_shared), .irq_direct(irq_direct));

// File: tb/gpio16_mask_bank_tb_top.sv
`timescale 1ns/1ps
module gpio16_mask_bank_tb_top;
  logic        clk = 0, rst_n = 0, bus_wr = 0;
  logic [7:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic [15:0] pin_in = 0, pin_out, pin_oe;
  logic        irq_shared;
  logic [7:0]  irq_direct;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  gpio16_mask_bank dut_i (.clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .irq_shared(irq_shared), .irq_direct(irq_direct));

  // {mask, value, expected latches}; latches start at 0
  localparam logic [47:0] VEC [6] = '{
    {16'hFFFF, 16'hA5C3, 16'hA5C3},
    {16'h00FF, 16'h0000, 16'hA500},
    {16'hF000, 16'hFFFF, 16'hF500},
    {16'h0000, 16'hFFFF, 16'hF500},
    {16'h0F0F, 16'h0101, 16'hF101},
    {16'h8001, 16'h0000, 16'h7100}};

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd_chk(string req, logic [7:0] a, logic [31:0] exp);
    bus_addr = a; #0.5;
    chk(req, bus_rdata, exp);
  endtask

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    rd_chk("R1", 8'h14, 32'h2);
    rd_chk("R1", 8'h00, 32'h0);
    chk("R1", {pin_oe, pin_out}, 32'h0);
    chk("R1", {23'h0, irq_shared, irq_direct}, 32'h0);
    // R7 writes ignored before enabling
    wr(8'h00, 32'hFFFF);
    rd_chk("R7", 8'h00, 32'h0);
    wr(8'h14, 32'h3);
    rd_chk("R7", 8'h14, 32'h3);
    wr(8'h14, 32'h1);
    // R2 direction
    wr(8'h00, 32'h00F0_0F0F);
    chk("R2", pin_oe, 16'h0F0F);
    rd_chk("R2", 8'h00, 32'h0F0F);
    // R3 masked vectors
    for (int i = 0; i < 6; i++) begin
      wr(8'h08, {VEC[i][47:32], VEC[i][31:16]});
      chk("R3", pin_out, VEC[i][15:0]);
      rd_chk("R3", 8'h08, {16'h0, VEC[i][15:0]});
    end
    // R4/R6 synchronizer lag
    pin_in = 16'h1234;
    @(negedge clk);
    rd_chk("R4", 8'h0C, 32'h0);
    @(negedge clk);
    rd_chk("R4", 8'h0C, 32'h1234);
    chk("R6", irq_direct, 8'h34);
    // R5 shared interrupt
    wr(8'h10, 32'h05);
    rd_chk("R5", 8'h10, 32'h05);
    pin_in = 16'h0200; repeat (2) @(negedge clk);
    chk("R5", irq_shared, 1'b0);
    pin_in = 16'h0400; repeat (2) @(negedge clk);
    chk("R5", irq_shared, 1'b1);
    wr(8'h10, 32'h00);
    chk("R5", irq_shared, 1'b0);
    wr(8'h10, 32'h05);
    // R9 unmapped
    wr(8'h04, 32'hFFFF_FFFF);
    rd_chk("R9", 8'h04, 32'h0);
    rd_chk("R9", 8'h00, 32'h0F0F);
    rd_chk("R9", 8'h08, 32'h7100);
    // R8 clock stopped
    wr(8'h14, 32'h0);
    rd_chk("R8", 8'h14, 32'h0);
    wr(8'h00, 32'h0000);
    wr(8'h08, 32'hFFFF_0000);
    pin_in = 16'h00FF; repeat (3) @(negedge clk);
    rd_chk("R8", 8'h00, 32'h0F0F);
    rd_chk("R8", 8'h0C, 32'h0400);
    chk("R8", pin_out, 16'h7100);
    wr(8'h14, 32'h1);
    repeat (2) @(negedge clk);
    rd_chk("R8", 8'h0C, 32'h00FF);
    chk("R8", pin_oe, 16'h0F0F);
    // R7 block reset clears state
    wr(8'h14, 32'h3);
    @(negedge clk);
    rd_chk("R7", 8'h00, 32'h0);
    rd_chk("R7", 8'h08, 32'h0);
    rd_chk("R7", 8'h10, 32'h0);
    rd_chk("R7", 8'h0C, 32'h0);
    chk("R7", {irq_shared, irq_direct}, 9'h0);
    wr(8'h14, 32'h2);
    rd_chk("R7", 8'h14, 32'h2);
    summary();
  end
endmodule